// File: doc/BRIEF.md
# Read-Modify-Write Memory Operand Sequencer

This block runs one memory-destination add with an immediate operand on a 16-bit datapath. On a start strobe it latches a base register, an index register, a 16-bit displacement, a 16-bit immediate and a segment value. It then uses one shared 16-bit adder for three jobs in turn: base plus index, that sum plus the displacement, and later the memory operand plus the immediate. The segment value, shifted left by four bits, is added to the effective address. The resulting 20-bit physical address is kept in a hidden temporary register.

The block reads the operand from the held address and adds the immediate. It updates carry, zero and sign flags, then writes the sum back through the same held address without computing it again. The memory port is shared with a code-prefetch requester. A pending prefetch gets the bus for one cycle before each data access. A prefetch to an unrelated address between the read and the write therefore cannot disturb the write-back address.

Top module: `rmw_seq`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `mem_we` and the three flags are 0. `mem_req` is 0 while `pf_req` is 0.
- R2: The effective address is (base + index + displacement) mod 2^16. The data read is issued at the physical address ((segment << 4) + effective address) mod 2^20, with `mem_req`=1 and `mem_we`=0.
- R3: The write-back uses exactly the address of the data read, even if a prefetch to another address used the bus between them.
- R4: The written data is (read data + immediate) mod 2^16. Read data is sampled in the cycle after the read request.
- R5: The flags are set from the sum: `flag_c` is the carry out of bit 15, `flag_z` is 1 when the sum is zero, and `flag_s` is bit 15 of the sum. They are valid from the cycle `done` is high.
- R6: In the read phase and in the write phase, a pending `pf_req` is granted the bus for exactly one cycle before the data access. During a grant, `mem_addr` equals `pf_addr` and `mem_we` is 0.
- R7: In any cycle that is not a data access, a `pf_req` is granted in the same cycle.
- R8: `done` is a single-cycle pulse in the cycle after the write. Without prefetches it comes 6 cycles after the edge that samples `start`. With `pf_req` held high it comes after 8 cycles.
- R9: `start` and operand inputs are ignored while `busy` is 1. Operands are captured only at the accepting edge.
- R10: A prefetch grant and a data access never share a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| base_val | input | 16 | Base register value |
| index_val | input | 16 | Index register value |
| disp | input | 16 | Address displacement |
| imm | input | 16 | Immediate addend |
| seg_base | input | 16 | Data segment value |
| mem_req | output | 1 | Bus cycle active (data or prefetch) |
| mem_we | output | 1 | Bus cycle is a data write |
| mem_addr | output | 20 | Bus address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| pf_req | input | 1 | Prefetch request |
| pf_addr | input | 20 | Prefetch address |
| pf_gnt | output | 1 | Prefetch owns the bus this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| flag_c | output | 1 | Carry from the add |
| flag_z | output | 1 | Sum was zero |
| flag_s | output | 1 | Sign of the sum |

## Verification
Some properties are checked on every cycle:
- a write always targets the most recent data-read address;
- grants only follow a request and never coincide with a write;
- `done` follows a write and lasts one cycle;
- the zero and sign flags agree with the last written word at completion.

Other behaviour only the scenarios can show: the address arithmetic and its wrap at 16 and 20 bits, the carry flag, cycle counts with and without prefetch pressure, and whether a second start pulse mid-operation is ignored. Those scenarios compare the design against a memory model and an expected-value queue.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_EA1   = 3'd1,
    ST_EA2   = 3'd2,
    ST_READ  = 3'd3,
    ST_EXEC  = 3'd4,
    ST_WRITE = 3'd5,
    ST_DONE  = 3'd6
  } seq_state_t;
endpackage

// File: rtl/rmw_alu.sv
module rmw_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] wide;
  always_comb begin
    wide = {1'b0, opa} + {1'b0, opb};
    sum  = wide[W-1:0];
    cout = wide[W];
  end
endmodule

// File: rtl/rmw_addr_unit.sv
module rmw_addr_unit #(
  parameter int W  = 16,
  parameter int AW = 20,
  parameter int SH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_tmp,
  input  logic          ld_phys,
  input  logic [W-1:0]  alu_sum,
  input  logic [W-1:0]  seg,
  output logic [W-1:0]  tmp_q,
  output logic [AW-1:0] phys_q
);
  localparam int SW = W + SH;
  logic [SW-1:0] seg_sh;
  logic [AW-1:0] phys_d;

  always_comb begin
    seg_sh = {seg, {SH{1'b0}}};
    phys_d = AW'(seg_sh) + AW'(alu_sum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmp_q  <= '0;
      phys_q <= '0;
    end else begin
      if (ld_tmp)  tmp_q  <= alu_sum;
      if (ld_phys) phys_q <= phys_d;
    end
  end
endmodule

// File: rtl/rmw_bus_arb.sv
module rmw_bus_arb (
  input  logic clk,
  input  logic rst,
  input  logic data_phase,
  input  logic pf_req,
  output logic pf_gnt,
  output logic data_go
);
  logic pf_served;

  always_comb begin
    pf_gnt  = pf_req && (!data_phase || !pf_served);
    data_go = data_phase && !pf_gnt;
  end

  always_ff @(posedge clk) begin
    if (rst)                     pf_served <= 1'b0;
    else if (data_go)            pf_served <= 1'b0;
    else if (data_phase && pf_gnt) pf_served <= 1'b1;
  end
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq #(
  parameter int W  = 16,
  parameter int AW = 20,
  parameter int SH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  base_val,
  input  logic [W-1:0]  index_val,
  input  logic [W-1:0]  disp,
  input  logic [W-1:0]  imm,
  input  logic [W-1:0]  seg_base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  input  logic          pf_req,
  input  logic [AW-1:0] pf_addr,
  output logic          pf_gnt,
  output logic          busy,
  output logic          done,
  output logic          flag_c,
  output logic          flag_z,
  output logic          flag_s
);
  import rmw_pkg::*;

  seq_state_t st;
  logic [W-1:0]  base_q, index_q, disp_q, imm_q, seg_q, res_q;
  logic [W-1:0]  alu_a, alu_b, alu_sum, tmp_q;
  logic          alu_c;
  logic [AW-1:0] phys_q;
  logic          data_phase, data_go;

  always_comb begin
    alu_a = '0;
    alu_b = '0;
    case (st)
      ST_EA1:  begin alu_a = base_q;    alu_b = index_q; end
      ST_EA2:  begin alu_a = tmp_q;     alu_b = disp_q;  end
      ST_EXEC: begin alu_a = mem_rdata; alu_b = imm_q;   end
      default: ;
    endcase
  end

  rmw_alu #(.W(W)) u_alu (
    .opa(alu_a), .opb(alu_b), .sum(alu_sum), .cout(alu_c)
  );

  rmw_addr_unit #(.W(W), .AW(AW), .SH(SH)) u_addr (
    .clk(clk), .rst(rst),
    .ld_tmp(st == ST_EA1), .ld_phys(st == ST_EA2),
    .alu_sum(alu_sum), .seg(seg_q),
    .tmp_q(tmp_q), .phys_q(phys_q)
  );

  assign data_phase = (st == ST_READ) || (st == ST_WRITE);

  rmw_bus_arb u_arb (
    .clk(clk), .rst(rst), .data_phase(data_phase),
    .pf_req(pf_req), .pf_gnt(pf_gnt), .data_go(data_go)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      base_q  <= '0;
      index_q <= '0;
      disp_q  <= '0;
      imm_q   <= '0;
      seg_q   <= '0;
      res_q   <= '0;
      flag_c  <= 1'b0;
      flag_z  <= 1'b0;
      flag_s  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          base_q  <= base_val;
          index_q <= index_val;
          disp_q  <= disp;
          imm_q   <= imm;
          seg_q   <= seg_base;
          st      <= ST_EA1;
        end
        ST_EA1:  st <= ST_EA2;
        ST_EA2:  st <= ST_READ;
        ST_READ: if (data_go) st <= ST_EXEC;
        ST_EXEC: begin
          res_q  <= alu_sum;
          flag_c <= alu_c;
          flag_z <= (alu_sum == '0);
          flag_s <= alu_sum[W-1];
          st     <= ST_WRITE;
        end
        ST_WRITE: if (data_go) st <= ST_DONE;
        ST_DONE:  st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = pf_gnt || data_go;
    mem_we    = data_go && (st == ST_WRITE);
    mem_addr  = pf_gnt ? pf_addr : phys_q;
    mem_wdata = res_q;
    busy      = (st != ST_IDLE);
    done      = (st == ST_DONE);
  end
endmodule

// File: rtl/rmw_seq_chk.sv
module rmw_seq_chk #(
  parameter int W  = 16,
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [W-1:0]  mem_wdata,
  input logic          pf_req,
  input logic          pf_gnt,
  input logic          done,
  input logic          flag_z,
  input logic          flag_s
);
  logic [AW-1:0] last_rd;
  logic [W-1:0]  last_wd;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_rd <= '0;
      last_wd <= '0;
    end else begin
      if (mem_req && !pf_gnt && !mem_we) last_rd <= mem_addr;
      if (mem_we) last_wd <= mem_wdata;
    end
  end

  p_wr_same_addr_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr == last_rd));
  p_gnt_no_write_r10: assert property (@(posedge clk) disable iff (rst)
    pf_gnt |-> !mem_we);
  p_gnt_needs_req_r7: assert property (@(posedge clk) disable iff (rst)
    pf_gnt |-> pf_req);
  p_done_after_wr_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> done);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_flags_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> ((flag_z == (last_wd == '0)) && (flag_s == last_wd[W-1])));
endmodule

bind rmw_seq rmw_seq_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pf_req(pf_req),
  .pf_gnt(pf_gnt), .done(done), .flag_z(flag_z), .flag_s(flag_s)
);

// File: tb/sim_rmw_seq.sv
module sim_rmw_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] base_val = '0, index_val = '0, disp = '0, imm = '0, seg_base = '0;
  logic        mem_req, mem_we, pf_gnt, busy, done, flag_c, flag_z, flag_s;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        pf_req = 1'b0;
  logic [19:0] pf_addr = 20'h0ABCD;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [19:0] addr;
    logic [15:0] wd;
    logic        c, z, s;
  } exp_t;
  exp_t q[$];

  logic [15:0] mem [logic [19:0]];

  always #5 clk = ~clk;

  rmw_seq u0 (
    .clk(clk), .rst(rst), .start(start), .base_val(base_val),
    .index_val(index_val), .disp(disp), .imm(imm), .seg_base(seg_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pf_req(pf_req),
    .pf_addr(pf_addr), .pf_gnt(pf_gnt), .busy(busy), .done(done),
    .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s)
  );

  function automatic logic [15:0] rd(input logic [19:0] a);
    if (mem.exists(a)) return mem[a];
    return a[15:0] ^ 16'hC3A5 ^ {12'h0, a[19:16]};
  endfunction

  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= rd(mem_addr);
    if (mem_req && mem_we)  mem[mem_addr] = mem_wdata;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (pf_gnt) check(!mem_we && mem_addr == pf_addr, "R6/R10 grant bus", {11'h0, mem_we, mem_addr}, {12'h0, pf_addr});
      if (q.size() > 0) begin
        if (mem_req && !pf_gnt && !mem_we) check(mem_addr == q[0].addr, "R2 read addr", mem_addr, q[0].addr);
        if (mem_we) begin
          check(mem_addr == q[0].addr, "R3 write addr", mem_addr, q[0].addr);
          check(mem_wdata == q[0].wd, "R4 write data", mem_wdata, q[0].wd);
        end
        if (done) begin
          check({flag_c, flag_z, flag_s} == {q[0].c, q[0].z, q[0].s}, "R5 flags",
                {flag_c, flag_z, flag_s}, {q[0].c, q[0].z, q[0].s});
          void'(q.pop_front());
        end
      end
    end
  end

  task automatic run_op(input logic [15:0] b, input logic [15:0] i, input logic [15:0] d,
                        input logic [15:0] im, input logic [15:0] sg, input bit pf,
                        input bit extra_start);
    exp_t e;
    logic [15:0] ea;
    logic [16:0] s17;
    int n, want;
    ea = b + i + d;
    e.addr = 20'({sg, 4'h0}) + 20'(ea);
    s17 = {1'b0, rd(e.addr)} + {1'b0, im};
    e.wd = s17[15:0];
    e.c = s17[16];
    e.z = (s17[15:0] == 16'h0);
    e.s = s17[15];
    q.push_back(e);
    want = pf ? 8 : 6;
    @(negedge clk);
    base_val = b; index_val = i; disp = d; imm = im; seg_base = sg;
    start = 1'b1; pf_req = pf;
    n = 0;
    while (n < 40) begin
      @(negedge clk);
      #2;
      n++;
      start = 1'b0;
      if (n == 1) begin
        base_val = ~b; index_val = b ^ 16'h1357; disp = ~d; imm = ~im; seg_base = ~sg;
        check(busy, "R9 busy after start", busy, 1);
        if (pf) check(pf_gnt && mem_addr == pf_addr, "R7 free-cycle grant", {11'h0, pf_gnt, mem_addr}, {12'h1, pf_addr});
      end
      if (extra_start && n == 2) start = 1'b1;
      if (done) break;
    end
    check(n == want, "R8 done latency", n, want);
    pf_req = 1'b0;
    start = 1'b0;
    @(negedge clk); #2;
    check(!done && !busy, "R8 single done pulse", {done, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(!busy && !done && !mem_req && !mem_we, "R1 reset outputs", {busy, done, mem_req, mem_we}, 0);
    check({flag_c, flag_z, flag_s} == 3'b000, "R1 reset flags", {flag_c, flag_z, flag_s}, 0);
    rst = 1'b0;
    run_op(16'h1000, 16'h0020, 16'h5FFD, 16'hEABF, 16'h2000, 1'b0, 1'b0); // R2 R4 basic
    run_op(16'hFFFF, 16'h0002, 16'hFFFF, 16'h0001, 16'h0100, 1'b0, 1'b0); // R2 EA wrap
    run_op(16'hFFF0, 16'h000F, 16'h0000, 16'h1234, 16'hFFFF, 1'b1, 1'b0); // R2 phys wrap, R3 R6
    begin
      logic [19:0] a;
      a = 20'h12340 + 20'h0055;
      mem[a] = 16'h8001;
    end
    run_op(16'h0050, 16'h0005, 16'h0000, 16'h7FFF, 16'h1234, 1'b0, 1'b0); // R5 carry, zero
    run_op(16'h0050, 16'h0005, 16'h0000, 16'h7FFF, 16'h1234, 1'b1, 1'b0); // R3 R4 re-read written value
    run_op(16'h0300, 16'h0400, 16'h0011, 16'h8000, 16'h0000, 1'b0, 1'b1); // R9 extra start ignored
    run_op(16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b1); // R6 R9
    begin
      @(negedge clk); pf_req = 1'b1; pf_addr = 20'h55555;
      #2;
      check(pf_gnt && mem_req && !mem_we && mem_addr == 20'h55555, "R7 idle grant",
            {pf_gnt, mem_req, mem_we, mem_addr}, {3'b110, 20'h55555});
      @(negedge clk); pf_req = 1'b0;
    end
    check(q.size() == 0, "R8 all ops completed", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R8 actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule